// File: doc/BRIEF.md
# MSI L1 Coherence Line Controller

This block is the coherence engine for one private L1 cache (split instruction and data arrays) sitting below an inclusive shared L2 that keeps lines in the MSI protocol. Each cycle it accepts at most one decoded event for one line address. An event is a processor access (load, instruction fetch, store), an eviction order (replacement, or a write-back because the line sits in the wrong array), a forwarded request from the L2 (invalidate-modified, invalidate-shared, downgrade), or a response from the L2 (data, data-then-shared, data-then-invalid, put acknowledge). Along with the event, the tag array supplies the stable state of the line and its current data.

For every event the block decides the reaction. It sends a request message to the L2 on one output stream and a response message on another. It orders the tag/data arrays to allocate, free or rewrite the line with a new stable state and access permission. It pulses a load or store completion strobe toward the processor. Between a miss or eviction and its conclusion, the line lives in a small table of transaction entries. Each entry holds the transient state and, for evictions, a copy of the data, so the block can answer forwarded requests after the line has left the arrays. Processor events that hit a transient line, or misses that find the table full, are held back and raise `stall`.

The event input and both message outputs are valid/ready streams. The event is taken on a cycle where `ev_valid` and `ev_ready` are both high. `ev_ready` drops while the event would stall, or while an output stream it must write still holds an unaccepted message. An output message keeps its valid and payload steady until it is accepted. The array-update and completion pins are single-cycle pulses without back-pressure. Each appears one cycle after the event is taken, as do new messages.

Top module: `msi_l1_line_ctrl`

## Requirements
- R1: After reset, `req_valid`, `rsp_valid`, the completion strobes and the array-update strobes are low, and `ev_ready` is high for a load on an absent line.
- R2: With a transaction entry open for the address, a load (kind 0), fetch (1), store (2), replacement (10) or write-back (11) is not taken: `stall`=1, `ev_ready`=0, and no message, strobe or array update follows.
- R3: For a line in state NP (0) or I (1), a load sends GETS (type 0) and a store sends GETX (type 2), both with `line_alloc_d`. A fetch sends GET_INSTR (type 1) with `line_alloc_i`. Each opens an entry and writes the line as state I with permission busy (3).
- R4: In S (2), loads and fetches pulse `load_done` with the line data, and a store sends UPGRADE (type 3) and writes permission busy. In M (3), a store pulses `store_done` with the line data. Load and store completion never pulse together.
- R5: A replacement or write-back frees the line. From S it sends PUTS (type 4) and from M it sends PUTX (type 5), each carrying the line data. From NP or I it sends nothing.
- R6: In M, an INV (kind 3) answers DATA (response type 0) with the line data and writes state I with permission invalid (0). A downgrade (kind 5) also answers DATA and writes state S with read-only (1). In S, an INV_S (kind 4) answers INV_ACK (type 1) and writes I.
- R7: After a read miss, INV_S is acknowledged with INV_ACK. The following DATA (kind 6) pulses `load_done` with the response data and writes it, ending in S, or in I if an INV_S was seen. DATA_I (kind 8) always ends in I.
- R8: After a store miss, INV and downgrade are held silently, INV_S is acknowledged at once, and after a downgrade an INV_S is held silently. The DATA that follows completes the store, returns DATA, and ends in I after an INV, S after a downgrade alone, and I after a downgrade then INV_S.
- R9: After a store miss with no forwarded request, DATA ends in M with read-write (2) and no response. DATA_S (kind 7) or DATA_I completes the store, returns DATA, and ends in S or I.
- R10: During an eviction, INV and downgrade answer DATA from the entry's copy, and a downgrade during a PUTX turns it into a PUTS wait. INV_S is acknowledged. PUT_ACK (kind 9) closes the entry with no message.
- R11: The transaction entry closes in the same cycle that a fill's completion strobe is raised, so the next processor event for that address is taken at once.
- R12: When every transaction entry is open, an event that needs a new entry raises `stall` and is not taken.
- R13: An output message stays valid and unchanged until accepted, and an event that needs a stream still holding an unaccepted message is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event taken when high with ev_valid |
| ev_kind | input | 4 | Event code |
| ev_addr | input | AW | Line address of the event |
| ev_data | input | DW | Data carried by an L2 data response |
| line_state | input | 2 | Stable state of the line from the tag array |
| line_data | input | DW | Current line data from the data array |
| stall | output | 1 | Offered event held back by a busy line or full table |
| req_valid | output | 1 | Request message valid |
| req_ready | input | 1 | Request message accepted |
| req_type | output | 3 | Request type |
| req_addr | output | AW | Request line address |
| req_data | output | DW | Request payload (evictions) |
| rsp_valid | output | 1 | Response message valid |
| rsp_ready | input | 1 | Response message accepted |
| rsp_type | output | 1 | Response type |
| rsp_addr | output | AW | Response line address |
| rsp_data | output | DW | Response payload |
| line_we | output | 1 | Rewrite state and permission of the line |
| line_wstate | output | 2 | New stable state |
| line_perm | output | 2 | New access permission |
| line_alloc_d | output | 1 | Allocate the line in the data array |
| line_alloc_i | output | 1 | Allocate the line in the instruction array |
| line_free | output | 1 | Free the line from the arrays |
| line_wdata_we | output | 1 | Write fill data into the line |
| line_wdata | output | DW | Fill data |
| load_done | output | 1 | Load or fetch completed |
| store_done | output | 1 | Store completed |
| done_addr | output | AW | Address of the completed access |
| done_data | output | DW | Line data for the completed access |

## Verification
Some properties are checked on every cycle. A processor event on a line with an open entry always stalls. The table never opens a second entry for one address and never allocates when full. Held output messages keep their payload. The two completion strobes never fire together. The race orderings can only be shown by the bench scenarios: each needs a particular sequence of forwarded requests before the data, and the scenarios check the right silence or answer and the final state and permission. The same holds for the answer taken from the entry's copy after the line is freed, for the entry closing on the fill cycle, and for stalling on a full table.

// File: rtl/msi_l1_pkg.sv
package msi_l1_pkg;

  typedef enum logic [3:0] {
    EV_LOAD      = 4'd0,
    EV_IFETCH    = 4'd1,
    EV_STORE     = 4'd2,
    EV_INV       = 4'd3,
    EV_INV_S     = 4'd4,
    EV_DOWNGRADE = 4'd5,
    EV_DATA      = 4'd6,
    EV_DATA_S    = 4'd7,
    EV_DATA_I    = 4'd8,
    EV_PUT_ACK   = 4'd9,
    EV_REPLACE   = 4'd10,
    EV_WRITEBACK = 4'd11
  } ev_kind_e;

  typedef enum logic [1:0] {
    LS_NP = 2'd0,
    LS_I  = 2'd1,
    LS_S  = 2'd2,
    LS_M  = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    TS_IS, TS_ISI, TS_IM, TS_IMI, TS_IMS, TS_IMSI, TS_SI, TS_MI
  } tr_st_e;

  typedef enum logic [2:0] {
    RQ_GETS      = 3'd0,
    RQ_GET_INSTR = 3'd1,
    RQ_GETX      = 3'd2,
    RQ_UPGRADE   = 3'd3,
    RQ_PUTS      = 3'd4,
    RQ_PUTX      = 3'd5
  } req_e;

  typedef enum logic {
    RS_DATA    = 1'b0,
    RS_INV_ACK = 1'b1
  } rsp_e;

  typedef enum logic [1:0] {
    PM_INVALID = 2'd0,
    PM_RO      = 2'd1,
    PM_RW      = 2'd2,
    PM_BUSY    = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    SRC_LINE  = 2'd0,
    SRC_EVENT = 2'd1,
    SRC_TBE   = 2'd2
  } src_e;

  typedef struct packed {
    logic     stall_busy;
    logic     need_tbe;
    logic     tbe_alloc;
    tr_st_e   tbe_new;
    logic     tbe_cap_data;
    logic     tbe_set;
    logic     tbe_free;
    logic     req_en;
    req_e     req_type;
    logic     req_line_data;
    logic     rsp_en;
    rsp_e     rsp_type;
    src_e     rsp_src;
    logic     line_we;
    line_st_e line_st;
    logic     line_busy;
    logic     line_alloc_d;
    logic     line_alloc_i;
    logic     line_free;
    logic     line_data_we;
    logic     load_done;
    logic     store_done;
    src_e     done_src;
  } act_t;

  function automatic perm_e perm_of(line_st_e st, logic busy);
    if (busy) return PM_BUSY;
    case (st)
      LS_S:    return PM_RO;
      LS_M:    return PM_RW;
      default: return PM_INVALID;
    endcase
  endfunction

  function automatic logic is_proc_event(ev_kind_e k);
    return (k == EV_LOAD) || (k == EV_IFETCH) || (k == EV_STORE) ||
           (k == EV_REPLACE) || (k == EV_WRITEBACK);
  endfunction

endpackage

// File: rtl/msi_l1_decide.sv
module msi_l1_decide
  import msi_l1_pkg::*;
(
  input  ev_kind_e kind,
  input  logic     tbe_hit,
  input  tr_st_e   tbe_state,
  input  line_st_e cur_line,
  output act_t     act
);

  function automatic act_t fill(act_t base, line_st_e fin, logic is_store, logic give_back);
    act_t a = base;
    a.tbe_free     = 1'b1;
    a.line_we      = 1'b1;
    a.line_st      = fin;
    a.line_data_we = 1'b1;
    a.done_src     = SRC_EVENT;
    a.load_done    = !is_store;
    a.store_done   = is_store;
    if (give_back) begin
      a.rsp_en   = 1'b1;
      a.rsp_type = RS_DATA;
      a.rsp_src  = SRC_EVENT;
    end
    return a;
  endfunction

  function automatic act_t open_miss(act_t base, tr_st_e ts, req_e rq, line_st_e keep);
    act_t a = base;
    a.need_tbe  = 1'b1;
    a.tbe_alloc = 1'b1;
    a.tbe_new   = ts;
    a.req_en    = 1'b1;
    a.req_type  = rq;
    a.line_we   = 1'b1;
    a.line_st   = keep;
    a.line_busy = 1'b1;
    return a;
  endfunction

  function automatic act_t evict(act_t base, tr_st_e ts, req_e rq);
    act_t a = base;
    a.need_tbe      = 1'b1;
    a.tbe_alloc     = 1'b1;
    a.tbe_new       = ts;
    a.tbe_cap_data  = 1'b1;
    a.req_en        = 1'b1;
    a.req_type      = rq;
    a.req_line_data = 1'b1;
    a.line_free     = 1'b1;
    return a;
  endfunction

  function automatic act_t answer(act_t base, rsp_e rt, src_e src);
    act_t a = base;
    a.rsp_en   = 1'b1;
    a.rsp_type = rt;
    a.rsp_src  = src;
    return a;
  endfunction

  always_comb begin
    act_t z;
    z = '0;
    act = z;
    if (tbe_hit) begin
      if (is_proc_event(kind)) begin
        act.stall_busy = 1'b1;
      end else begin
        case (tbe_state)
          TS_IS: begin
            if (kind == EV_INV_S) begin
              act = answer(z, RS_INV_ACK, SRC_LINE);
              act.tbe_set = 1'b1;
              act.tbe_new = TS_ISI;
            end else if (kind == EV_DATA) act = fill(z, LS_S, 1'b0, 1'b0);
            else if (kind == EV_DATA_I) act = fill(z, LS_I, 1'b0, 1'b0);
          end
          TS_ISI: if (kind == EV_DATA) act = fill(z, LS_I, 1'b0, 1'b0);
          TS_IM: begin
            case (kind)
              EV_INV:       begin act.tbe_set = 1'b1; act.tbe_new = TS_IMI; end
              EV_DOWNGRADE: begin act.tbe_set = 1'b1; act.tbe_new = TS_IMS; end
              EV_INV_S:     act = answer(z, RS_INV_ACK, SRC_LINE);
              EV_DATA:      act = fill(z, LS_M, 1'b1, 1'b0);
              EV_DATA_S:    act = fill(z, LS_S, 1'b1, 1'b1);
              EV_DATA_I:    act = fill(z, LS_I, 1'b1, 1'b1);
              default:      act = z;
            endcase
          end
          TS_IMI: if (kind == EV_DATA) act = fill(z, LS_I, 1'b1, 1'b1);
          TS_IMS: begin
            if (kind == EV_DATA) act = fill(z, LS_S, 1'b1, 1'b1);
            else if (kind == EV_INV_S) begin
              act.tbe_set = 1'b1;
              act.tbe_new = TS_IMSI;
            end
          end
          TS_IMSI: if (kind == EV_DATA) act = fill(z, LS_I, 1'b1, 1'b1);
          TS_SI: begin
            if (kind == EV_INV_S) act = answer(z, RS_INV_ACK, SRC_LINE);
            else if (kind == EV_PUT_ACK) act.tbe_free = 1'b1;
          end
          TS_MI: begin
            if (kind == EV_INV) act = answer(z, RS_DATA, SRC_TBE);
            else if (kind == EV_DOWNGRADE) begin
              act = answer(z, RS_DATA, SRC_TBE);
              act.tbe_set = 1'b1;
              act.tbe_new = TS_SI;
            end else if (kind == EV_PUT_ACK) act.tbe_free = 1'b1;
          end
          default: act = z;
        endcase
      end
    end else begin
      case (cur_line)
        LS_NP, LS_I: begin
          case (kind)
            EV_REPLACE, EV_WRITEBACK: act.line_free = 1'b1;
            EV_LOAD: begin
              act = open_miss(z, TS_IS, RQ_GETS, LS_I);
              act.line_alloc_d = 1'b1;
            end
            EV_IFETCH: begin
              act = open_miss(z, TS_IS, RQ_GET_INSTR, LS_I);
              act.line_alloc_i = 1'b1;
            end
            EV_STORE: begin
              act = open_miss(z, TS_IM, RQ_GETX, LS_I);
              act.line_alloc_d = 1'b1;
            end
            default: act = z;
          endcase
        end
        LS_S: begin
          case (kind)
            EV_LOAD, EV_IFETCH:       act.load_done = 1'b1;
            EV_STORE:                 act = open_miss(z, TS_IM, RQ_UPGRADE, LS_S);
            EV_REPLACE, EV_WRITEBACK: act = evict(z, TS_SI, RQ_PUTS);
            EV_INV_S: begin
              act = answer(z, RS_INV_ACK, SRC_LINE);
              act.line_we = 1'b1;
              act.line_st = LS_I;
            end
            default: act = z;
          endcase
        end
        default: begin
          case (kind)
            EV_LOAD, EV_IFETCH:       act.load_done = 1'b1;
            EV_STORE:                 act.store_done = 1'b1;
            EV_REPLACE, EV_WRITEBACK: act = evict(z, TS_MI, RQ_PUTX);
            EV_INV: begin
              act = answer(z, RS_DATA, SRC_LINE);
              act.line_we = 1'b1;
              act.line_st = LS_I;
            end
            EV_DOWNGRADE: begin
              act = answer(z, RS_DATA, SRC_LINE);
              act.line_we = 1'b1;
              act.line_st = LS_S;
            end
            default: act = z;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/msi_l1_tbe_table.sv
module msi_l1_tbe_table
  import msi_l1_pkg::*;
#(
  parameter int NTBE = 2,
  parameter int AW   = 16,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  input  logic          alloc_en,
  input  tr_st_e        alloc_state,
  input  logic [DW-1:0] alloc_data,
  input  logic          set_en,
  input  tr_st_e        set_state,
  input  logic          free_en,
  output logic          hit,
  output tr_st_e        hit_state,
  output logic [DW-1:0] hit_data,
  output logic          full
);

  localparam int IW = (NTBE > 1) ? $clog2(NTBE) : 1;

  logic [NTBE-1:0] vld;
  logic [AW-1:0]   tag [NTBE];
  tr_st_e          st  [NTBE];
  logic [DW-1:0]   dat [NTBE];
  logic [NTBE-1:0] hit_vec;
  logic [IW-1:0]   hit_idx;
  logic [IW-1:0]   free_idx;

  for (genvar g = 0; g < NTBE; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tag[g] == lk_addr);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = 0; i < NTBE; i++) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
    for (int i = NTBE - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IW'(i);
    end
  end

  assign hit       = |hit_vec;
  assign full      = &vld;
  assign hit_state = st[hit_idx];
  assign hit_data  = dat[hit_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (alloc_en) vld[free_idx] <= 1'b1;
      if (free_en)  vld[hit_idx]  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      tag[free_idx] <= lk_addr;
      st[free_idx]  <= alloc_state;
      dat[free_idx] <= alloc_data;
    end
    if (set_en) st[hit_idx] <= set_state;
  end

  AST_TBE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full) else $error("alloc into full table"); // R12
  AST_TBE_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)) else $error("duplicate entry"); // R11
  AST_TBE_NO_DUP_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !hit) else $error("alloc over open entry"); // R2
  AST_TBE_OP_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en || free_en) |-> hit) else $error("update of missing entry"); // R10

endmodule

// File: rtl/msi_l1_out_slice.sv
module msi_l1_out_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         space
);

  assign space = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid <= 1'b0;
    else if (load)   valid <= 1'b1;
    else if (ready)  valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) dout <= din;
  end

  AST_SLICE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout))) else $error("message dropped"); // R13
  AST_SLICE_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> space) else $error("overwrite of held message"); // R13

endmodule

// File: rtl/msi_l1_line_ctrl.sv
module msi_l1_line_ctrl
  import msi_l1_pkg::*;
#(
  parameter int NTBE = 2,
  parameter int AW   = 16,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [3:0]    ev_kind,
  input  logic [AW-1:0] ev_addr,
  input  logic [DW-1:0] ev_data,
  input  logic [1:0]    line_state,
  input  logic [DW-1:0] line_data,
  output logic          stall,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [2:0]    req_type,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_type,
  output logic [AW-1:0] rsp_addr,
  output logic [DW-1:0] rsp_data,
  output logic          line_we,
  output logic [1:0]    line_wstate,
  output logic [1:0]    line_perm,
  output logic          line_alloc_d,
  output logic          line_alloc_i,
  output logic          line_free,
  output logic          line_wdata_we,
  output logic [DW-1:0] line_wdata,
  output logic          load_done,
  output logic          store_done,
  output logic [AW-1:0] done_addr,
  output logic [DW-1:0] done_data
);

  localparam int RQW = 3 + AW + DW;
  localparam int RSW = 1 + AW + DW;

  ev_kind_e      kind;
  line_st_e      cur_line;
  act_t          act;
  logic          tbe_hit, tbe_full;
  tr_st_e        tbe_state;
  logic [DW-1:0] tbe_data;
  logic          req_space, rsp_space;
  logic          fire, blocked, hold;
  logic [DW-1:0] rsp_pay, done_pay;

  assign kind     = ev_kind_e'(ev_kind);
  assign cur_line = line_st_e'(line_state);

  msi_l1_decide u_decide (
    .kind      (kind),
    .tbe_hit   (tbe_hit),
    .tbe_state (tbe_state),
    .cur_line  (cur_line),
    .act       (act)
  );

  msi_l1_tbe_table #(.NTBE(NTBE), .AW(AW), .DW(DW)) u_tbe (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_addr     (ev_addr),
    .alloc_en    (fire && act.tbe_alloc),
    .alloc_state (act.tbe_new),
    .alloc_data  (act.tbe_cap_data ? line_data : '0),
    .set_en      (fire && act.tbe_set),
    .set_state   (act.tbe_new),
    .free_en     (fire && act.tbe_free),
    .hit         (tbe_hit),
    .hit_state   (tbe_state),
    .hit_data    (tbe_data),
    .full        (tbe_full)
  );

  assign hold    = act.stall_busy || (act.need_tbe && tbe_full);
  assign blocked = hold || (act.req_en && !req_space) || (act.rsp_en && !rsp_space);
  assign ev_ready = !blocked;
  assign fire     = ev_valid && ev_ready;
  assign stall    = ev_valid && hold;

  always_comb begin
    case (act.rsp_src)
      SRC_EVENT: rsp_pay = ev_data;
      SRC_TBE:   rsp_pay = tbe_data;
      default:   rsp_pay = (act.rsp_type == RS_DATA) ? line_data : '0;
    endcase
    done_pay = (act.done_src == SRC_EVENT) ? ev_data : line_data;
  end

  msi_l1_out_slice #(.W(RQW)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire && act.req_en),
    .din   ({act.req_type, ev_addr, (act.req_line_data ? line_data : {DW{1'b0}})}),
    .ready (req_ready),
    .valid (req_valid),
    .dout  ({req_type, req_addr, req_data}),
    .space (req_space)
  );

  msi_l1_out_slice #(.W(RSW)) u_rsp (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire && act.rsp_en),
    .din   ({act.rsp_type, ev_addr, rsp_pay}),
    .ready (rsp_ready),
    .valid (rsp_valid),
    .dout  ({rsp_type, rsp_addr, rsp_data}),
    .space (rsp_space)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_we       <= 1'b0;
      line_alloc_d  <= 1'b0;
      line_alloc_i  <= 1'b0;
      line_free     <= 1'b0;
      line_wdata_we <= 1'b0;
      load_done     <= 1'b0;
      store_done    <= 1'b0;
    end else begin
      line_we       <= fire && act.line_we;
      line_alloc_d  <= fire && act.line_alloc_d;
      line_alloc_i  <= fire && act.line_alloc_i;
      line_free     <= fire && act.line_free;
      line_wdata_we <= fire && act.line_data_we;
      load_done     <= fire && act.load_done;
      store_done    <= fire && act.store_done;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      line_wstate <= act.line_st;
      line_perm   <= perm_of(act.line_st, act.line_busy);
      line_wdata  <= ev_data;
      done_addr   <= ev_addr;
      done_data   <= done_pay;
    end
  end

  AST_BUSY_LINE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && tbe_hit && is_proc_event(kind)) |-> (stall && !ev_ready)) else $error("transient not stalled"); // R2
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_done && store_done)) else $error("both completions"); // R4
  AST_FULL_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !tbe_hit && tbe_full && !line_state[1] &&
     (kind == EV_LOAD || kind == EV_STORE || kind == EV_IFETCH)) |-> stall) else $error("miss not stalled"); // R12
  AST_FILL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wdata_we) |-> (load_done || store_done)) else $error("fill without completion"); // R11

endmodule

// File: tb/msi_l1_line_ctrl_tb.sv
`timescale 1ns/1ps
module msi_l1_line_ctrl_tb;

  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          ev_valid = 1'b0, ev_ready;
  logic [3:0]    ev_kind = '0;
  logic [AW-1:0] ev_addr = '0;
  logic [DW-1:0] ev_data = '0;
  logic [1:0]    line_state = '0;
  logic [DW-1:0] line_data = '0;
  logic          stall;
  logic          req_valid, req_ready = 1'b1;
  logic [2:0]    req_type;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          rsp_valid, rsp_ready = 1'b1;
  logic          rsp_type;
  logic [AW-1:0] rsp_addr;
  logic [DW-1:0] rsp_data;
  logic          line_we, line_alloc_d, line_alloc_i, line_free, line_wdata_we;
  logic [1:0]    line_wstate, line_perm;
  logic [DW-1:0] line_wdata, done_data;
  logic          load_done, store_done;
  logic [AW-1:0] done_addr;

  msi_l1_line_ctrl #(.NTBE(2), .AW(AW), .DW(DW)) u_dut (.*);

  int checks = 0;
  int fails  = 0;
  logic last_ready;

  logic [3+AW+DW-1:0] req_q [$];
  string              req_tag_q [$];
  logic [1+AW+DW-1:0] rsp_q [$];
  string              rsp_tag_q [$];

  localparam logic [AW-1:0] A = 16'h0010, B = 16'h0020, C = 16'h0030;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic exp_req(logic [2:0] t, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    req_q.push_back({t, a, d});
    req_tag_q.push_back(tag);
  endtask

  task automatic exp_rsp(logic t, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    rsp_q.push_back({t, a, d});
    rsp_tag_q.push_back(tag);
  endtask

  // monitor: compares handshaken messages against the scoreboard
  always @(posedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      checks++;
      if (req_q.size() == 0) begin
        fails++;
        $display("FAIL R13 unexpected req: actual %0h expected none", {req_type, req_addr, req_data});
      end else begin
        automatic logic [3+AW+DW-1:0] e = req_q.pop_front();
        automatic string tg = req_tag_q.pop_front();
        if (e !== {req_type, req_addr, req_data}) begin
          fails++;
          $display("FAIL %s req: actual %0h expected %0h", tg, {req_type, req_addr, req_data}, e);
        end
      end
    end
    if (rst_n && rsp_valid && rsp_ready) begin
      checks++;
      if (rsp_q.size() == 0) begin
        fails++;
        $display("FAIL R13 unexpected rsp: actual %0h expected none", {rsp_type, rsp_addr, rsp_data});
      end else begin
        automatic logic [1+AW+DW-1:0] e = rsp_q.pop_front();
        automatic string tg = rsp_tag_q.pop_front();
        if (e !== {rsp_type, rsp_addr, rsp_data}) begin
          fails++;
          $display("FAIL %s rsp: actual %0h expected %0h", tg, {rsp_type, rsp_addr, rsp_data}, e);
        end
      end
    end
  end

  task automatic send(logic [3:0] k, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] ls, logic [DW-1:0] ld);
    @(negedge clk);
    ev_kind = k; ev_addr = a; ev_data = d; line_state = ls; line_data = ld;
    ev_valid = 1'b1;
    #1 last_ready = ev_ready;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic try_stall(logic [3:0] k, logic [AW-1:0] a, logic [1:0] ls, string tag);
    @(negedge clk);
    ev_kind = k; ev_addr = a; ev_data = '0; line_state = ls; line_data = '0;
    ev_valid = 1'b1;
    #1;
    chk(tag, "stall", stall, 1);
    chk(tag, "ev_ready", ev_ready, 0);
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    chk(tag, "no strobe", {line_we, line_free, load_done, store_done, req_valid, rsp_valid}, 0);
  endtask

  task automatic chk_line(string tag, logic [1:0] st, logic [1:0] pm);
    chk(tag, "line_we", line_we, 1);
    chk(tag, "line_wstate", line_wstate, st);
    chk(tag, "line_perm", line_perm, pm);
  endtask

  task automatic chk_done(string tag, logic ld, logic sd, logic [DW-1:0] d);
    chk(tag, "load_done", load_done, ld);
    chk(tag, "store_done", store_done, sd);
    chk(tag, "done_data", done_data, d);
  endtask

  bit finished = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "req_valid", req_valid, 0);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "strobes", {line_we, line_free, load_done, store_done}, 0);
    chk("R1", "ev_ready", ev_ready, 1);

    // R3 load miss, R2 stall, R7 fill, R11 entry freed
    exp_req(0, A, 0, "R3");
    send(0, A, 0, 0, 0);
    chk_line("R3", 1, 3);
    chk("R3", "alloc_d", line_alloc_d, 1);
    try_stall(0, A, 1, "R2");
    try_stall(10, A, 1, "R2");
    send(6, A, 32'hA1, 1, 0);
    chk_done("R7", 1, 0, 32'hA1);
    chk_line("R7", 2, 1);
    chk("R7", "wdata", line_wdata, 32'hA1);
    send(0, A, 0, 2, 32'h77);
    chk("R11", "taken", last_ready, 1);
    chk_done("R4", 1, 0, 32'h77);

    // R3 fetch miss, R7 ISI
    exp_req(1, B, 0, "R3");
    send(1, B, 0, 1, 0);
    chk("R3", "alloc_i", line_alloc_i, 1);
    exp_rsp(1, B, 0, "R7");
    send(4, B, 0, 1, 0);
    send(6, B, 32'hB2, 1, 0);
    chk_done("R7", 1, 0, 32'hB2);
    chk_line("R7", 1, 0);

    // R7 DATA_I
    exp_req(0, C, 0, "R3");
    send(0, C, 0, 0, 0);
    send(8, C, 32'hD1, 1, 0);
    chk_done("R7", 1, 0, 32'hD1);
    chk_line("R7", 1, 0);

    // R8 IM + INV -> IMI
    exp_req(2, C, 0, "R3");
    send(2, C, 0, 0, 0);
    send(3, C, 0, 1, 0);
    chk("R8", "silent inv", rsp_valid, 0);
    exp_rsp(0, C, 32'hC3, "R8");
    send(6, C, 32'hC3, 1, 0);
    chk_done("R8", 0, 1, 32'hC3);
    chk_line("R8", 1, 0);

    // R4 upgrade, R8 IMS -> IMSI
    exp_req(3, A, 0, "R4");
    send(2, A, 0, 2, 32'h77);
    chk_line("R4", 2, 3);
    send(5, A, 0, 2, 0);
    chk("R8", "silent dg", rsp_valid, 0);
    send(4, A, 0, 2, 0);
    chk("R8", "silent inv_s", rsp_valid, 0);
    exp_rsp(0, A, 32'hA4, "R8");
    send(6, A, 32'hA4, 2, 0);
    chk_done("R8", 0, 1, 32'hA4);
    chk_line("R8", 1, 0);

    // R8 IMS alone -> S
    exp_req(2, B, 0, "R3");
    send(2, B, 0, 1, 0);
    send(5, B, 0, 1, 0);
    exp_rsp(0, B, 32'hE1, "R8");
    send(6, B, 32'hE1, 1, 0);
    chk_line("R8", 2, 1);

    // R8 INV_S acked in IM, R9 DATA_S
    exp_req(2, B, 0, "R3");
    send(2, B, 0, 1, 0);
    exp_rsp(1, B, 0, "R8");
    send(4, B, 0, 1, 0);
    exp_rsp(0, B, 32'hB5, "R9");
    send(7, B, 32'hB5, 1, 0);
    chk_done("R9", 0, 1, 32'hB5);
    chk_line("R9", 2, 1);

    // R9 DATA_I
    exp_req(2, B, 0, "R3");
    send(2, B, 0, 1, 0);
    exp_rsp(0, B, 32'hD2, "R9");
    send(8, B, 32'hD2, 1, 0);
    chk_line("R9", 1, 0);

    // R9 plain DATA -> M
    exp_req(2, C, 0, "R3");
    send(2, C, 0, 0, 0);
    send(6, C, 32'hC6, 1, 0);
    chk_done("R9", 0, 1, 32'hC6);
    chk_line("R9", 3, 2);
    chk("R9", "no rsp", rsp_valid, 0);

    // R4 M hits, R6 forwarded
    send(2, C, 0, 3, 32'hC7);
    chk_done("R4", 0, 1, 32'hC7);
    send(1, C, 0, 3, 32'hC7);
    chk_done("R4", 1, 0, 32'hC7);
    exp_rsp(0, C, 32'hC7, "R6");
    send(5, C, 0, 3, 32'hC7);
    chk_line("R6", 2, 1);
    exp_rsp(0, C, 32'hC8, "R6");
    send(3, C, 0, 3, 32'hC8);
    chk_line("R6", 1, 0);
    exp_rsp(1, C, 0, "R6");
    send(4, C, 0, 2, 32'hC8);
    chk_line("R6", 1, 0);

    // R5 PUTX, R10 answers from entry
    exp_req(5, A, 32'h5A, "R5");
    send(10, A, 0, 3, 32'h5A);
    chk("R5", "line_free", line_free, 1);
    exp_rsp(0, A, 32'h5A, "R10");
    send(3, A, 0, 0, 0);
    exp_rsp(0, A, 32'h5A, "R10");
    send(5, A, 0, 0, 0);
    exp_rsp(1, A, 0, "R10");
    send(4, A, 0, 0, 0);
    send(9, A, 0, 0, 0);
    chk("R10", "silent ack", {req_valid, rsp_valid}, 0);
    exp_req(0, A, 0, "R10");
    send(0, A, 0, 0, 0);
    chk("R10", "entry closed", last_ready, 1);
    send(6, A, 32'h1, 1, 0);

    // R5 PUTS via write-back, NP eviction
    exp_req(4, B, 32'hB9, "R5");
    send(11, B, 0, 2, 32'hB9);
    chk("R5", "line_free", line_free, 1);
    send(9, B, 0, 0, 0);
    send(10, C, 0, 1, 0);
    chk("R5", "np free", line_free, 1);
    chk("R5", "no req", req_valid, 0);

    // R12 full table
    exp_req(0, A, 0, "R12");
    send(0, A, 0, 0, 0);
    exp_req(0, B, 0, "R12");
    send(0, B, 0, 0, 0);
    try_stall(0, C, 0, "R12");
    send(6, A, 32'h2, 1, 0);
    exp_req(0, C, 0, "R12");
    send(0, C, 0, 0, 0);
    chk("R12", "taken after free", last_ready, 1);
    send(6, B, 32'h3, 1, 0);
    send(6, C, 32'h4, 1, 0);

    // R13 back-pressure
    req_ready = 1'b0;
    exp_req(0, A, 0, "R13");
    send(0, A, 0, 0, 0);
    @(negedge clk);
    ev_kind = 0; ev_addr = B; line_state = 0; ev_valid = 1'b1;
    #1 chk("R13", "ev_ready held", ev_ready, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R13", "req held", req_valid, 1);
    chk("R13", "req addr held", req_addr, A);
    exp_req(0, B, 0, "R13");
    req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    send(6, A, 32'h5, 1, 0);
    send(6, B, 32'h6, 1, 0);

    repeat (4) @(negedge clk);
    chk("R13", "req left", req_q.size(), 0);
    chk("R13", "rsp left", rsp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule